// File: doc/BRIEF.md
# Serial programming host sequencer

This block is the host side of a four-byte serial programming link. It drives a target's reset line, serial clock and data-out line, and reads the target's data-in line. When a session starts, it pulses the target's reset high with the clock held low, then waits a startup delay. Next it sends the programming-enable frame and checks the byte that comes back during the third byte. If that byte is wrong, it pulses reset again and retries, up to a limit, and then reports an error.

Once the link is in step, the sequencer pulls 16-bit words from a simple request/valid source. It loads each word into the target's page buffer, low byte first and then high byte. When a page is full, or the source marks the last word, it issues the page-write frame. It then holds the link quiet for the flash write time before the next page. On a chip-erased target it leaves out every load frame whose data byte is 0xFF. After the final page and its wait, it drives the target's reset high so the target runs its new program. All delays are parameters counted in host clock cycles.

Top module: `isp_host_seq`

## Requirements
- R1: After a synchronous reset, `tgt_rst`, `tgt_sck`, `tgt_mosi`, `wd_req`, `busy`, `done` and `err` are all 0.
- R2: On `start`, `tgt_rst` goes high in the next cycle with `tgt_sck` low and stays high for at least RST_PULSE_CYC cycles. After it falls, at least STARTUP_CYC cycles pass before the first rising edge of `tgt_sck`.
- R3: Every frame is 32 bits, sent most significant bit first. `tgt_mosi` is stable while `tgt_sck` is high. Each high phase lasts exactly SCK_HALF cycles and each low phase at least SCK_HALF. `tgt_sck` is low whenever `tgt_rst` is high, and `tgt_rst` changes only while `tgt_sck` is low.
- R4: The enable frame is bytes 0xAC, 0x53, 0x00, 0x00. The byte read on `tgt_miso` during the third byte is compared with 0x53. All four bytes are always sent.
- R5: On a mismatch, the sequencer repeats the reset pulse and the startup wait, then sends a new enable frame. `wd_req` stays low until an enable frame has echoed 0x53.
- R6: After MAX_TRIES enable frames in a row that all mismatch, `err` is 1 and `busy` is 0. No further frames are sent, and `tgt_rst` stays low until the next `start`.
- R7: A word is taken in a cycle where `wd_req` and `wd_valid` are both high. For word index k within its page, it is loaded with frame 0x40, 0x00, k, low byte, then frame 0x48, 0x00, k, high byte.
- R8: Word addresses start at 0 in each session. After a page's last word (index 2^PAGE_BITS-1), or after the word flagged by `wd_last`, the frame 0x4C, page-address high byte, page-address low byte, 0x00 is sent. The page address is the word address with its low PAGE_BITS bits cleared.
- R9: After a page-write frame, neither a rising edge of `tgt_sck` nor a change of `tgt_rst` occurs for at least FLASH_WAIT_CYC cycles.
- R10: With `chip_erased` high at `start`, a load frame whose data byte is 0xFF is not sent. With it low, such frames are sent.
- R11: After the last page's wait, `tgt_rst` is 1, `done` is 1 and `busy` is 0 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session (pulse) |
| chip_erased | input | 1 | Target is erased; skip 0xFF data bytes |
| wd_req | output | 1 | Sequencer is ready for the next word |
| wd_valid | input | 1 | Word source has a word |
| wd_data | input | 16 | Word to program |
| wd_last | input | 1 | Word is the last of the session |
| tgt_rst | output | 1 | Target reset line level (1 = run) |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished, target released |
| err | output | 1 | Enable retries exhausted |

## Verification
Two events can land in the same cycle: a page filling up and the source flagging the last word. One session provokes this by supplying exactly one page, so one page-write frame must both close the page and end the session. The bench judges it by the page frame's address, by a full flash wait before reset rises, and by `done`. A second such meeting is the last allowed enable attempt. Sessions where the echo fails exactly MAX_TRIES-1 times and exactly MAX_TRIES times must end in data transfer and in `err`, respectively.

// File: rtl/isp_host_pkg.sv
// Package: shared opcodes, frame kinds and sequencer states for the
// serial programming host. Assumes a target that decodes four-byte frames.
package isp_host_pkg;
    localparam logic [7:0] OP_ENABLE0 = 8'hAC;
    localparam logic [7:0] OP_ENABLE1 = 8'h53;
    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_WR_PAGE = 8'h4C;
    localparam logic [7:0] SYNC_ECHO  = 8'h53;

    typedef enum logic [1:0] {
        FR_ENABLE,
        FR_LOAD_LO,
        FR_LOAD_HI,
        FR_PAGE
    } frame_kind_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PULSE,
        S_SETTLE,
        S_EN_SEND,
        S_EN_WAIT,
        S_FETCH,
        S_LO_CHK,
        S_LO_SEND,
        S_LO_WAIT,
        S_HI_CHK,
        S_HI_SEND,
        S_HI_WAIT,
        S_WORD_END,
        S_PG_SEND,
        S_PG_WAIT,
        S_PG_PAUSE,
        S_DONE,
        S_ERROR
    } seq_state_e;
endpackage

// File: rtl/isp_delay_timer.sv
// Loadable down-counter used for every wait of the sequencer.
// Assumes load and the expiry test are never needed in the same cycle.
module isp_delay_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Count down to zero after each load, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // An idle timer stays at zero until reloaded (guards R9 waits).
    assert_timer_rests_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/isp_frame_build.sv
// Assembles the 32-bit frame for the requested kind from the current
// word address and data byte. Assumes ADDR_W <= 16.
module isp_frame_build
    import isp_host_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 4
) (
    input  frame_kind_e       kind,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [7:0]        data_byte,
    output logic [31:0]       frame
);
    localparam logic [15:0] OFF_MASK = 16'((32'd1 << PAGE_BITS) - 32'd1);

    logic [15:0] addr16;
    logic [15:0] page16;
    logic [15:0] off16;

    generate
        if (ADDR_W < 16) begin : g_pad
            assign addr16 = {{(16 - ADDR_W){1'b0}}, word_addr};
        end else begin : g_full
            assign addr16 = word_addr[15:0];
        end
    endgenerate

    assign page16 = addr16 & ~OFF_MASK;
    assign off16  = addr16 & OFF_MASK;

    // Select the four bytes of the frame.
    always_comb begin
        unique case (kind)
            FR_ENABLE:  frame = {OP_ENABLE0, OP_ENABLE1, 8'h00, 8'h00};
            FR_LOAD_LO: frame = {OP_LOAD_LO, 8'h00, off16[7:0], data_byte};
            FR_LOAD_HI: frame = {OP_LOAD_HI, 8'h00, off16[7:0], data_byte};
            default:    frame = {OP_WR_PAGE, page16[15:8], page16[7:0], 8'h00};
        endcase
    end
endmodule

// File: rtl/isp_frame_shifter.sv
// Shifts one 32-bit frame out MSB first with SCK idle low. Data changes
// while SCK is low, and the input is sampled as SCK rises. The byte seen
// during the third byte is held in echo. Assumes go only while idle.
module isp_frame_shifter #(
    parameter int SCK_HALF = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [31:0] frame,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        fr_done,
    output logic [7:0]  echo
);
    localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [HW-1:0] cnt_q;
    logic [4:0]    bit_q;
    logic [31:0]   sh_q;
    logic          sck_q;
    logic          busy_q;
    logic [7:0]    echo_q;

    // Half-period pacing, bit counting and shifting for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            echo_q <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            cnt_q  <= HW'(SCK_HALF - 1);
            bit_q  <= '0;
            sh_q   <= frame;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - HW'(1);
            end else if (!sck_q) begin
                sck_q <= 1'b1;
                cnt_q <= HW'(SCK_HALF - 1);
                if (bit_q[4:3] == 2'b10) begin
                    echo_q <= {echo_q[6:0], miso};
                end
            end else begin
                sck_q <= 1'b0;
                cnt_q <= HW'(SCK_HALF - 1);
                sh_q  <= {sh_q[30:0], 1'b0};
                bit_q <= bit_q + 5'd1;
                if (bit_q == 5'd31) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = busy_q & sh_q[31];
    assign busy    = busy_q;
    assign echo    = echo_q;
    assign fr_done = busy_q && sck_q && (cnt_q == '0) && (bit_q == 5'd31);

    // SCK only toggles inside a frame (R3).
    assert_sck_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> busy_q);
    // A new frame never starts over a running one, so all bytes go out (R4).
    assert_go_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q);
endmodule

// File: rtl/isp_host_seq.sv
// Top of the serial programming host. It runs the reset pulse, startup
// wait, enable with echo check and bounded retry, word loading with
// erased-byte skip, page write and write-time pause, then releases the
// target. Assumes the word source answers wd_req with a one-cycle wd_valid.
module isp_host_seq
    import isp_host_pkg::*;
#(
    parameter int SCK_HALF       = 8,
    parameter int RST_PULSE_CYC  = 32,
    parameter int STARTUP_CYC    = 320000,
    parameter int FLASH_WAIT_CYC = 72000,
    parameter int PAGE_BITS      = 4,
    parameter int ADDR_W         = 10,
    parameter int MAX_TRIES      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        chip_erased,
    output logic        wd_req,
    input  logic        wd_valid,
    input  logic [15:0] wd_data,
    input  logic        wd_last,
    output logic        tgt_rst,
    output logic        tgt_sck,
    output logic        tgt_mosi,
    input  logic        tgt_miso,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int T_A   = (STARTUP_CYC > FLASH_WAIT_CYC) ? STARTUP_CYC : FLASH_WAIT_CYC;
    localparam int TMAX  = (T_A > RST_PULSE_CYC) ? T_A : RST_PULSE_CYC;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] waddr_q;
    logic [15:0]       word_q;
    logic              last_q;
    logic              erased_q;
    logic [TRY_W-1:0]  tries_q;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              go;
    frame_kind_e       kind;
    logic [31:0]       frame;
    logic [7:0]        echo;
    logic              fr_done;
    logic              sh_busy;
    logic              skip_lo, skip_hi, page_end;

    assign skip_lo  = erased_q && (word_q[7:0] == 8'hFF);
    assign skip_hi  = erased_q && (word_q[15:8] == 8'hFF);
    assign page_end = &waddr_q[PAGE_BITS-1:0];

    isp_delay_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_val),
        .expired (tmr_exp)
    );

    isp_frame_build #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_build (
        .kind      (kind),
        .word_addr (waddr_q),
        .data_byte ((kind == FR_LOAD_HI) ? word_q[15:8] : word_q[7:0]),
        .frame     (frame)
    );

    isp_frame_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .frame   (frame),
        .miso    (tgt_miso),
        .sck     (tgt_sck),
        .mosi    (tgt_mosi),
        .busy    (sh_busy),
        .fr_done (fr_done),
        .echo    (echo)
    );

    // Next state, frame launch and timer loads.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go       = 1'b0;
        kind     = FR_ENABLE;
        unique case (state_q)
            S_IDLE, S_DONE, S_ERROR: begin
                if (start) begin
                    state_d  = S_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_PULSE_CYC);
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STARTUP_CYC);
                end
            end
            S_SETTLE:  if (tmr_exp) state_d = S_EN_SEND;
            S_EN_SEND: begin
                go      = 1'b1;
                kind    = FR_ENABLE;
                state_d = S_EN_WAIT;
            end
            S_EN_WAIT: begin
                if (fr_done) begin
                    if (echo == SYNC_ECHO) begin
                        state_d = S_FETCH;
                    end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
                        state_d = S_ERROR;
                    end else begin
                        state_d  = S_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RST_PULSE_CYC);
                    end
                end
            end
            S_FETCH:   if (wd_valid) state_d = S_LO_CHK;
            S_LO_CHK:  state_d = skip_lo ? S_HI_CHK : S_LO_SEND;
            S_LO_SEND: begin
                go      = 1'b1;
                kind    = FR_LOAD_LO;
                state_d = S_LO_WAIT;
            end
            S_LO_WAIT: begin
                kind = FR_LOAD_LO;
                if (fr_done) state_d = S_HI_CHK;
            end
            S_HI_CHK:  state_d = skip_hi ? S_WORD_END : S_HI_SEND;
            S_HI_SEND: begin
                go      = 1'b1;
                kind    = FR_LOAD_HI;
                state_d = S_HI_WAIT;
            end
            S_HI_WAIT: begin
                kind = FR_LOAD_HI;
                if (fr_done) state_d = S_WORD_END;
            end
            S_WORD_END: state_d = (page_end || last_q) ? S_PG_SEND : S_FETCH;
            S_PG_SEND: begin
                go      = 1'b1;
                kind    = FR_PAGE;
                state_d = S_PG_WAIT;
            end
            S_PG_WAIT: begin
                kind = FR_PAGE;
                if (fr_done) begin
                    state_d  = S_PG_PAUSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(FLASH_WAIT_CYC);
                end
            end
            S_PG_PAUSE: if (tmr_exp) state_d = last_q ? S_DONE : S_FETCH;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Session context: erase flag, retry count, word address and word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erased_q <= 1'b0;
            tries_q  <= '0;
            waddr_q  <= '0;
            word_q   <= '0;
            last_q   <= 1'b0;
        end else begin
            if ((state_q == S_IDLE || state_q == S_DONE || state_q == S_ERROR) && start) begin
                erased_q <= chip_erased;
                tries_q  <= '0;
                waddr_q  <= '0;
            end
            if (state_q == S_EN_WAIT && fr_done && echo != SYNC_ECHO) begin
                tries_q <= tries_q + TRY_W'(1);
            end
            if (state_q == S_FETCH && wd_valid) begin
                word_q <= wd_data;
                last_q <= wd_last;
            end
            if ((state_q == S_WORD_END && !(page_end || last_q)) ||
                (state_q == S_PG_PAUSE && tmr_exp && !last_q)) begin
                waddr_q <= waddr_q + ADDR_W'(1);
            end
        end
    end

    assign wd_req  = (state_q == S_FETCH);
    assign tgt_rst = (state_q == S_PULSE) || (state_q == S_DONE);
    assign done    = (state_q == S_DONE);
    assign err     = (state_q == S_ERROR);
    assign busy    = !(state_q == S_IDLE || state_q == S_DONE || state_q == S_ERROR);

    // Target reset high implies clock low (R3).
    assert_sck_low_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> !tgt_sck);
    // Reset line moves only while the clock is low (R3).
    assert_rst_moves_sck_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_rst) |-> !tgt_sck);
    // An accepted word closes the request for at least a cycle (R7).
    assert_one_word_per_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_req && wd_valid) |=> !wd_req);
    // Error state is quiet: no clock, no request, target held (R6).
    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!tgt_sck && !wd_req && !tgt_rst && !sh_busy));
    // Done means the target is released and the session is over (R11).
    assert_done_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tgt_rst && !busy));
endmodule

// File: tb/isp_host_seq_tb_top.sv
module isp_host_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 3;
    localparam int RSTP       = 5;
    localparam int STARTUP    = 60;
    localparam int FLASHW     = 100;
    localparam int PBITS      = 2;
    localparam int PWORDS     = 1 << PBITS;
    localparam int TRIES      = 3;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n = 1'b0, start = 1'b0, chip_erased = 1'b0;
    logic        wd_req, wd_valid = 1'b0, wd_last = 1'b0;
    logic [15:0] wd_data = '0;
    logic        tgt_rst, tgt_sck, tgt_mosi, tgt_miso = 1'b0;
    logic        busy, done, err;

    isp_host_seq #(
        .SCK_HALF(H), .RST_PULSE_CYC(RSTP), .STARTUP_CYC(STARTUP),
        .FLASH_WAIT_CYC(FLASHW), .PAGE_BITS(PBITS), .ADDR_W(10), .MAX_TRIES(TRIES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_erased(chip_erased),
        .wd_req(wd_req), .wd_valid(wd_valid), .wd_data(wd_data), .wd_last(wd_last),
        .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Target model state and expected traffic.
    logic [31:0] exp_q[$];
    logic [15:0] supply[$];
    int  echo_fail_left = 0;
    bit  synced = 0;
    logic [31:0] rx_sh;
    int  nbits, hi_len, rst_hi_len, since_fall, pg_gap;
    bit  await_rise, pg_pending, pg_gap_on, cur_en;
    logic prev_sck, prev_rst;

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'hAC:   return "R4";
            8'h40:   return "R7";
            8'h48:   return "R7";
            default: return "R8";
        endcase
    endfunction

    // Behavioural target, sampled every clock away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            nbits = 0; hi_len = 0; rst_hi_len = 0; since_fall = 0; pg_gap = 0;
            await_rise = 0; pg_pending = 0; pg_gap_on = 0; cur_en = 0;
            rx_sh = '0; prev_sck = 0; prev_rst = 0; tgt_miso = 0;
        end else begin
            if (tgt_rst) begin
                rst_hi_len = prev_rst ? rst_hi_len + 1 : 1;
                nbits = 0;
                if (tgt_sck) chk(0, "R3", "sck high during reset", 1, 0);
            end
            if (prev_rst != tgt_rst && pg_gap_on) begin
                chk(pg_gap >= FLASHW, "R9", "reset change after page write", pg_gap, FLASHW);
                pg_gap_on = 0;
            end
            if (prev_rst && !tgt_rst) begin
                chk(rst_hi_len >= RSTP, "R2", "reset pulse width", rst_hi_len, RSTP);
                since_fall = 0;
                await_rise = 1;
            end
            if (prev_sck && !tgt_sck) begin
                chk(hi_len == H, "R3", "sck high width", hi_len, H);
                if (pg_pending) begin
                    pg_pending = 0; pg_gap_on = 1; pg_gap = 0;
                end
            end
            if (!prev_sck && tgt_sck) begin
                if (await_rise) begin
                    chk(since_fall >= STARTUP, "R2", "startup wait", since_fall, STARTUP);
                    await_rise = 0;
                end
                if (pg_gap_on) begin
                    chk(pg_gap >= FLASHW, "R9", "sck after page write", pg_gap, FLASHW);
                    pg_gap_on = 0;
                end
                rx_sh = {rx_sh[30:0], tgt_mosi};
                nbits++;
                hi_len = 0;
                if (nbits == 16) cur_en = (rx_sh[15:0] == 16'hAC53);
                if (nbits == 32) begin
                    if (exp_q.size() == 0) begin
                        chk(0, tag_of(rx_sh[31:24]), "unexpected frame", rx_sh, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(rx_sh == e, tag_of(e[31:24]), "frame content", rx_sh, e);
                    end
                    if (rx_sh[31:16] == 16'hAC53) begin
                        if (echo_fail_left > 0) echo_fail_left--;
                        else synced = 1;
                    end
                    if (rx_sh[31:24] == 8'h4C) pg_pending = 1;
                    nbits = 0;
                    cur_en = 0;
                end
            end
            if (tgt_sck) hi_len++;
            if (!tgt_rst) since_fall++;
            if (pg_gap_on) pg_gap++;
            if (wd_req && !synced) chk(0, "R5", "word requested before sync", 1, 0);
            if (nbits >= 16 && nbits < 24 && cur_en) begin
                logic [7:0] ob;
                ob = (echo_fail_left > 0) ? 8'hA5 : 8'h53;
                tgt_miso = ob[7 - (nbits - 16)];
            end else begin
                tgt_miso = 1'b0;
            end
            prev_sck = tgt_sck;
            prev_rst = tgt_rst;
        end
    end

    // Word source: answer a request with one valid cycle.
    always @(negedge clk) begin
        if (wd_valid) begin
            void'(supply.pop_front());
            wd_valid = 1'b0;
        end else if (rst_n && wd_req && supply.size() > 0) begin
            wd_valid = 1'b1;
            wd_data  = supply[0];
            wd_last  = (supply.size() == 1);
        end
    end

    task automatic run_session(input bit erased, input int nfail,
                               input logic [15:0] words[$], input bit expect_err);
        int n_en;
        int t;
        exp_q.delete();
        echo_fail_left = nfail;
        synced = 0;
        n_en = expect_err ? TRIES : nfail + 1;
        for (int i = 0; i < n_en; i++) exp_q.push_back(32'hAC53_0000);
        if (!expect_err) begin
            for (int i = 0; i < words.size(); i++) begin
                logic [7:0] off;
                logic [15:0] pg;
                off = 8'(i % PWORDS);
                if (!(erased && words[i][7:0] == 8'hFF))
                    exp_q.push_back({8'h40, 8'h00, off, words[i][7:0]});
                if (!(erased && words[i][15:8] == 8'hFF))
                    exp_q.push_back({8'h48, 8'h00, off, words[i][15:8]});
                if (int'(off) == PWORDS - 1 || i == words.size() - 1) begin
                    pg = 16'(i - int'(off));
                    exp_q.push_back({8'h4C, pg[15:8], pg[7:0], 8'h00});
                end
            end
            supply = words;
        end
        @(posedge clk); #1;
        chip_erased = erased;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(tgt_rst == 1'b1 && tgt_sck == 1'b0, "R2", "reset pulse begins", {tgt_rst, tgt_sck}, 2'b10);
        t = 0;
        while (!(done || err) && t < 40000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 40000, "R11", "session end reached", t, 40000);
        repeat (FLASHW + 60) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "frames left unsent", exp_q.size(), 0);
        if (expect_err) begin
            chk(err == 1'b1, "R6", "err raised", err, 1);
            chk(busy == 1'b0 && tgt_rst == 1'b0, "R6", "idle and held", {busy, tgt_rst}, 0);
        end else begin
            chk(done == 1'b1 && tgt_rst == 1'b1, "R11", "target released", {done, tgt_rst}, 2'b11);
            chk(busy == 1'b0 && err == 1'b0, "R11", "not busy", {busy, err}, 0);
            chk(supply.size() == 0, "R7", "all words taken", supply.size(), 0);
        end
    endtask

    // Watchdog: a hung run is a failure that still reports.
    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > WD_LIMIT && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc_total, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] wa[$];
        logic [15:0] wb[$];
        logic [15:0] wc[$];
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({tgt_rst, tgt_sck, tgt_mosi, wd_req, busy, done, err} == 7'b0, "R1",
            "outputs in reset", {tgt_rst, tgt_sck, tgt_mosi, wd_req, busy, done, err}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({tgt_rst, tgt_sck, tgt_mosi, wd_req, busy, done, err} == 7'b0, "R1",
            "outputs after reset", {tgt_rst, tgt_sck, tgt_mosi, wd_req, busy, done, err}, 0);

        // R10 erased skip, R5 one retry, two pages with a partial last page.
        wa = '{16'h12FF, 16'hFFFF, 16'hA55A, 16'hFF34, 16'h0102, 16'h8877};
        run_session(1'b1, 1, wa, 1'b0);

        // R10 not erased: 0xFF bytes are sent; last word closes a full page (R8).
        wb = '{16'hFFFF, 16'h00FF, 16'h1234, 16'hFF00};
        run_session(1'b0, 0, wb, 1'b0);

        // R6: echo never matches.
        wc = '{16'h5555};
        run_session(1'b0, 99, wc, 1'b1);

        // R5: last allowed attempt succeeds; address restarts at zero (R8).
        run_session(1'b1, TRIES - 1, wc, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule